// File: doc/BRIEF.md
# Masked Vector Element Blend Unit

The block merges two 512-bit source vectors into one destination vector. It decides each element separately, using one bit of a mask word per element. A clear mask bit takes the element from the first source. A set mask bit takes it from the second source. The mask only chooses between the sources. It never blocks a write: every active lane gets data from one source or the other.

Elements can be 32 or 64 bits wide. The active vector length can be 128, 256 or 512 bits. A broadcast flag replaces the second source with one scalar, copied into every lane. A zeroing flag writes all zeros into the lanes whose mask bit is clear.

The block treats element contents as raw bits and performs no arithmetic on them. The result is registered, and a one-cycle valid strobe marks it.

Top module: `blend_unit`

## Requirements
- R1: For lane i, counted from the least significant lane, mask bit i = 0 selects that lane of src_a_i and mask bit i = 1 selects that lane of src_b_i.
- R2: With zero_i = 1, every active lane whose mask bit is 0 is written with all zeros instead of src_a_i data; lanes whose mask bit is 1 are unaffected.
- R3: wide_i = 1 gives 64-bit lanes controlled by mask_i[7:0]; wide_i = 0 gives 32-bit lanes controlled by mask_i[15:0].
- R4: vlen_i selects the active length: 2'b00 = 128 bits, 2'b01 = 256 bits, 2'b10 and 2'b11 = 512 bits. All dst_o bits above the active length are written as zero.
- R5: Mask bits at or above the active lane count have no effect on dst_o.
- R6: With bcast_i = 1, the lowest lane-width bits of src_b_i (32 or 64 bits) stand in for the second-source value of every lane. The remaining bits of src_b_i have no effect.
- R7: A result is loaded into dst_o on the clock edge that samples in_valid_i = 1. out_valid_o is high for exactly the following cycle for each accepted input.
- R8: Reset clears dst_o and out_valid_o. dst_o holds its value while in_valid_i is low, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operands valid this cycle |
| src_a_i | input | 512 | First source vector |
| src_b_i | input | 512 | Second source vector, or scalar in its low bits |
| mask_i | input | 16 | Per-lane select bits, bit 0 = lane 0 |
| wide_i | input | 1 | 1 = 64-bit lanes, 0 = 32-bit lanes |
| vlen_i | input | 2 | Active vector length select |
| bcast_i | input | 1 | Replicate the low src_b_i element into all lanes |
| zero_i | input | 1 | Zero lanes whose mask bit is clear |
| out_valid_o | output | 1 | Result strobe, one cycle |
| dst_o | output | 512 | Registered blended vector |

## Verification
Broadcast and zeroing can both act on the same transfer. The replicated scalar then feeds the lanes with a set mask bit, while the lanes with a clear bit are forced to zero. Random transfers cover all four combinations of the two flags, with random masks, at both lane widths and all length codes. Directed cases pair an all-ones upper src_b_i with broadcast and zeroing at a short length. Each result is compared with a bench model that rebuilds every 32-bit slice from its lane index, its mask bit and the active length.

// File: rtl/blend_pkg.sv
package blend_pkg;
  typedef enum logic [1:0] {
    VL_128  = 2'b00,
    VL_256  = 2'b01,
    VL_512  = 2'b10,
    VL_512X = 2'b11
  } vlen_e;
endpackage

// File: rtl/blend_ctrl.sv
// Per-slice control: which source, and whether the slice is inside the vector length.
module blend_ctrl #(
  parameter int DW = 512,
  parameter int SW = 32,
  parameter int WW = 64,
  localparam int NS = DW / SW,
  localparam int SPL = WW / SW,
  localparam int CW = $clog2(NS) + 1
) (
  input  logic [NS-1:0] mask_i,
  input  logic          wide_i,
  input  logic [1:0]    vlen_i,
  output logic [NS-1:0] pick_b_o,
  output logic [NS-1:0] active_o
);
  import blend_pkg::*;

  localparam int S128 = 128 / SW;
  localparam int S256 = 256 / SW;

  logic [CW-1:0] n_act;

  always_comb begin
    unique case (vlen_e'(vlen_i))
      VL_128:  n_act = CW'(S128);
      VL_256:  n_act = CW'(S256);
      default: n_act = CW'(NS);
    endcase
  end

  for (genvar s = 0; s < NS; s++) begin : g_slice
    assign active_o[s] = CW'(s) < n_act;
    assign pick_b_o[s] = wide_i ? mask_i[s / SPL] : mask_i[s];
  end
endmodule

// File: rtl/blend_bsrc.sv
// Second-operand shaping: pass-through or scalar replication.
module blend_bsrc #(
  parameter int DW = 512,
  parameter int SW = 32,
  parameter int WW = 64,
  localparam int NS = DW / SW,
  localparam int SPL = WW / SW
) (
  input  logic [DW-1:0] src_b_i,
  input  logic          bcast_i,
  input  logic          wide_i,
  output logic [DW-1:0] b_eff_o
);
  for (genvar s = 0; s < NS; s++) begin : g_slice
    localparam int PART = s % SPL;
    logic [SW-1:0] rep;
    assign rep = wide_i ? src_b_i[PART*SW +: SW] : src_b_i[SW-1:0];
    assign b_eff_o[s*SW +: SW] = bcast_i ? rep : src_b_i[s*SW +: SW];
  end
endmodule

// File: rtl/blend_mux.sv
module blend_mux #(
  parameter int DW = 512,
  parameter int SW = 32,
  localparam int NS = DW / SW
) (
  input  logic [DW-1:0] src_a_i,
  input  logic [DW-1:0] b_eff_i,
  input  logic [NS-1:0] pick_b_i,
  input  logic [NS-1:0] active_i,
  input  logic          zero_i,
  output logic [DW-1:0] res_o
);
  for (genvar s = 0; s < NS; s++) begin : g_slice
    logic [SW-1:0] a_or_z;
    assign a_or_z = zero_i ? '0 : src_a_i[s*SW +: SW];
    assign res_o[s*SW +: SW] = !active_i[s] ? '0 :
                               pick_b_i[s]  ? b_eff_i[s*SW +: SW] : a_or_z;
  end
endmodule

// File: rtl/blend_unit.sv
module blend_unit #(
  parameter int DW = 512,
  parameter int SW = 32,
  parameter int WW = 64,
  localparam int NS = DW / SW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic [DW-1:0] src_a_i,
  input  logic [DW-1:0] src_b_i,
  input  logic [NS-1:0] mask_i,
  input  logic          wide_i,
  input  logic [1:0]    vlen_i,
  input  logic          bcast_i,
  input  logic          zero_i,
  output logic          out_valid_o,
  output logic [DW-1:0] dst_o
);
  localparam int VB128 = 128;

  logic [DW-1:0] b_eff, res;
  logic [NS-1:0] pick_b, active;

  blend_ctrl #(.DW(DW), .SW(SW), .WW(WW)) u_ctrl (
    .mask_i   (mask_i),
    .wide_i   (wide_i),
    .vlen_i   (vlen_i),
    .pick_b_o (pick_b),
    .active_o (active)
  );

  blend_bsrc #(.DW(DW), .SW(SW), .WW(WW)) u_bsrc (
    .src_b_i (src_b_i),
    .bcast_i (bcast_i),
    .wide_i  (wide_i),
    .b_eff_o (b_eff)
  );

  blend_mux #(.DW(DW), .SW(SW)) u_mux (
    .src_a_i  (src_a_i),
    .b_eff_i  (b_eff),
    .pick_b_i (pick_b),
    .active_i (active),
    .zero_i   (zero_i),
    .res_o    (res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      dst_o       <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) dst_o <= res;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o); // R7
  AST_VALID_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o); // R7
  AST_DST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(dst_o)); // R8
  AST_SEL_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !wide_i && !zero_i && !mask_i[0])
      |=> dst_o[SW-1:0] == $past(src_a_i[SW-1:0])); // R1
  AST_ZERO_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && zero_i && !wide_i && !mask_i[0]) |=> dst_o[SW-1:0] == '0); // R2
  AST_WIDE_SEL_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && wide_i && mask_i[0] && !bcast_i)
      |=> dst_o[WW-1:0] == $past(src_b_i[WW-1:0])); // R3
  AST_SHORT_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && vlen_i == 2'b00) |=> dst_o[DW-1:VB128] == '0); // R4
  AST_BCAST_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && bcast_i && !wide_i && mask_i[3])
      |=> dst_o[4*SW-1:3*SW] == $past(src_b_i[SW-1:0])); // R6
endmodule

// File: tb/sim_blend_unit.sv
`timescale 1ns/1ps
module sim_blend_unit;
  localparam int DW = 512;
  localparam int NS = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [DW-1:0] src_a = '0, src_b = '0;
  logic [NS-1:0] mask = '0;
  logic wide = 1'b0, bcast = 1'b0, zero = 1'b0;
  logic [1:0] vlen = 2'b00;
  logic out_valid;
  logic [DW-1:0] dst;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  blend_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid),
    .src_a_i(src_a), .src_b_i(src_b), .mask_i(mask), .wide_i(wide),
    .vlen_i(vlen), .bcast_i(bcast), .zero_i(zero),
    .out_valid_o(out_valid), .dst_o(dst)
  );

  function automatic logic [DW-1:0] rnd512();
    logic [DW-1:0] v;
    for (int k = 0; k < DW/32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [DW-1:0] ref_blend(
    input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [NS-1:0] m,
    input logic w64, input logic [1:0] vl, input logic bc, input logic z);
    logic [DW-1:0] r;
    int bits;
    bits = (vl == 2'b00) ? 128 : (vl == 2'b01) ? 256 : 512;
    r = '0;
    for (int j = 0; j < NS; j++) begin
      int lane;
      int part;
      logic [31:0] bs;
      lane = w64 ? j / 2 : j;
      part = w64 ? j % 2 : 0;
      bs = bc ? b[part*32 +: 32] : b[j*32 +: 32];
      if (j * 32 < bits)
        r[j*32 +: 32] = m[lane] ? bs : (z ? 32'h0 : a[j*32 +: 32]);
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  logic [DW-1:0] last_exp = '0;

  task automatic run(input logic [DW-1:0] a, input logic [DW-1:0] b,
                     input logic [NS-1:0] m, input logic w, input logic [1:0] vl,
                     input logic bc, input logic z, input string tag);
    logic [DW-1:0] e;
    @(negedge clk);
    src_a = a; src_b = b; mask = m; wide = w; vlen = vl; bcast = bc; zero = z;
    in_valid = 1'b1;
    e = ref_blend(a, b, m, w, vl, bc, z);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1, "R7 strobe", {511'b0, out_valid}, {511'b0, 1'b1});
    chk(dst === e, tag, dst, e);
    last_exp = e;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] a, b, d0;
    void'($urandom(32'd20240611));
    #12;
    chk(dst === '0 && out_valid === 1'b0, "R8 reset", dst, '0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 plain select, 32-bit lanes, full length
    a = rnd512(); b = rnd512();
    run(a, b, 16'hA5C3, 1'b0, 2'b10, 1'b0, 1'b0, "R1 select");
    // R7 single cycle, R8 hold under changing inputs
    @(negedge clk);
    src_a = rnd512(); src_b = rnd512(); mask = 16'hFFFF; zero = 1'b1;
    chk(out_valid === 1'b0, "R7 one cycle", {511'b0, out_valid}, '0);
    chk(dst === last_exp, "R8 hold", dst, last_exp);
    @(negedge clk);
    chk(dst === last_exp, "R8 hold2", dst, last_exp);

    // R2 zeroing
    run(a, b, 16'h0F0F, 1'b0, 2'b10, 1'b0, 1'b1, "R2 zeroing");
    run(a, b, 16'h0000, 1'b0, 2'b10, 1'b0, 1'b1, "R2 all zero");
    // R3 wide lanes
    run(a, b, 16'h0055, 1'b1, 2'b10, 1'b0, 1'b0, "R3 wide");
    run(a, b, 16'hFF00, 1'b1, 2'b10, 1'b0, 1'b0, "R3 wide upper mask ignored");
    // R4 lengths
    run(a, b, 16'hFFFF, 1'b0, 2'b00, 1'b0, 1'b0, "R4 len128");
    run(a, b, 16'h0000, 1'b1, 2'b01, 1'b0, 1'b0, "R4 len256");
    run(a, b, 16'h3333, 1'b0, 2'b11, 1'b0, 1'b0, "R4 code3 full");
    // R5 mask bits beyond active lanes
    run(a, b, 16'h000A, 1'b0, 2'b00, 1'b0, 1'b0, "R5 base");
    d0 = dst;
    run(a, b, 16'hFFFA, 1'b0, 2'b00, 1'b0, 1'b0, "R5 upper set");
    chk(dst === d0, "R5 no effect", dst, d0);
    run(a, b, 16'h00F2, 1'b1, 2'b01, 1'b0, 1'b0, "R5 wide base");
    d0 = dst;
    run(a, b, 16'hFFF2, 1'b1, 2'b01, 1'b0, 1'b0, "R5 wide upper set");
    chk(dst === d0, "R5 wide no effect", dst, d0);
    // R6 broadcast, upper src_b bits ignored
    run(a, b, 16'hFFFF, 1'b0, 2'b10, 1'b1, 1'b0, "R6 bcast32");
    d0 = dst;
    run(a, {b[DW-1:32] ^ {(DW-32){1'b1}}, b[31:0]}, 16'hFFFF, 1'b0, 2'b10, 1'b1, 1'b0,
        "R6 bcast32 upper flip");
    chk(dst === d0, "R6 upper ignored", dst, d0);
    run(a, b, 16'h00C9, 1'b1, 2'b10, 1'b1, 1'b0, "R6 bcast64");
    // broadcast and zeroing together
    run(a, {DW{1'b1}}, 16'h0069, 1'b0, 2'b00, 1'b1, 1'b1, "R2/R6 combined short");
    run(a, b, 16'h00A6, 1'b1, 2'b01, 1'b1, 1'b1, "R2/R6 combined wide");
    // back-to-back
    @(negedge clk);
    src_a = a; src_b = b; mask = 16'h1234; wide = 0; vlen = 2; bcast = 0; zero = 0;
    in_valid = 1'b1;
    @(negedge clk);
    chk(dst === ref_blend(a, b, 16'h1234, 0, 2, 0, 0), "R7 b2b first", dst,
        ref_blend(a, b, 16'h1234, 0, 2, 0, 0));
    mask = 16'h4321;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1 && dst === ref_blend(a, b, 16'h4321, 0, 2, 0, 0),
        "R7 b2b second", dst, ref_blend(a, b, 16'h4321, 0, 2, 0, 0));

    // random sweep: R1 R2 R3 R4 R6
    for (int n = 0; n < 400; n++) begin
      logic [1:0] vl;
      vl = 2'($urandom);
      run(rnd512(), rnd512(), 16'($urandom), 1'($urandom), vl,
          1'(n[0]), 1'(n[1]), "R1/R2/R3/R4/R6 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule